// File: doc/BRIEF.md
# Adaptive Probabilistic Replacement Controller

This block decides what a flow classification cache does on a lookup miss. It tracks a running hit-ratio estimate and updates it once per lookup with exponential smoothing. The weight on the old value is nine tenths. After a miss it may grant a replacement, and if it does, it names the way of the indexed set that takes the new flow. When the set still has a free way, the first free way is always filled. When every way is occupied, the block replaces an entry only with a probability equal to the current hit-ratio estimate, and it picks the victim pseudo-randomly. So a cache that is mostly hitting keeps turning over its contents, and a cache that is thrashing mostly leaves resident entries alone.

The surrounding cache pipeline presents one lookup per cycle at most. With each lookup it gives a hit flag and the valid bits of the indexed set. One cycle later it reads the replacement grant and the victim way. The estimate is held as an unsigned fraction in which 0x10000 would stand for 1.0. It is also available as an output.

Top module: `prob_repl_ctrl`

## Requirements
- R1: While reset is held (synchronous, active low), and in the first cycle after it, `hit_est` is 0x8000, `repl_en` is 0 and `repl_way` is 0.
- R2: A lookup with `lookup_hit`=1 sets `hit_est` at the next edge to floor(h*58982/65536)+6554, where h is the value before the edge.
- R3: A lookup with `lookup_hit`=0 sets `hit_est` at the next edge to floor(h*58982/65536).
- R4: In a cycle with `lookup_vld`=0, `hit_est` keeps its value and `repl_en` is 0 in the next cycle.
- R5: After a miss on a set whose `set_valid` has at least one zero bit, `repl_en` is 1 in the next cycle and `repl_way` is the index of the lowest zero bit.
- R6: The random source is a 16-bit register. It is seeded to 0xACE1 under reset. Every cycle after reset it shifts left by one, and the new bit 0 is bit15 XOR bit13 XOR bit12 XOR bit10. After a miss on a fully valid set, `repl_en` is 1 in the next cycle exactly when the register value in the miss cycle is below the `hit_est` value of that cycle.
- R7: When R6 grants a replacement, `repl_way` is (bits 7..0 of the random register in the miss cycle) modulo WAYS. Whenever no replacement is granted, `repl_way` is 0.
- R8: `repl_en` is a one-cycle result. It is 0 after any hit, and after a miss it is 1 for at most the single following cycle unless another miss follows.
- R9: `hit_est` never wraps. A long run of hits drives it to 65000 or above, and a long run of misses drives it to exactly 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lookup_vld | input | 1 | A lookup is presented this cycle |
| lookup_hit | input | 1 | The lookup hit (meaningful with lookup_vld) |
| set_valid | input | WAYS | Valid bits of the indexed set, bit i for way i |
| repl_en | output | 1 | Replacement granted for the previous cycle's miss |
| repl_way | output | $clog2(WAYS) | Way to overwrite when repl_en is 1, else 0 |
| hit_est | output | 16 | Current smoothed hit-ratio estimate |

## Verification
A corrupted estimate register shows directly on `hit_est` one cycle after the lookup that updates it. Through R6 it also skews which later misses on full sets are granted. A fault in the random register or its feedback taps is invisible on hits and on sets with free ways. It first shows on the next miss against a full set, as a wrong grant or a wrong victim in the following cycle. The bench therefore runs long miss sequences on full sets, with the estimate both high and low, so that grants and refusals both occur and every register fault reaches the ports within a few dozen lookups.

// File: rtl/prc_pkg.sv
// Shared constants for the probabilistic replacement controller.
// Assumes a 16-bit estimate and random register; the smoothing weight
// of 0.9 is derived from the estimate width, rounded to nearest.
package prc_pkg;
    localparam int EST_W     = 16;
    localparam int RND_W     = 16;
    localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;
    localparam logic [RND_W-1:0] RND_TAPS = 16'hB400;   // bits 15,13,12,10
    localparam int ALPHA_Q   = (9 * (1 << EST_W) + 5) / 10;   // 58982
    localparam int BLEND_Q   = (1 << EST_W) - ALPHA_Q;        // 6554
    localparam logic [EST_W-1:0] EST_INIT = 16'h8000;
endpackage

// File: rtl/prc_lfsr.sv
// Free-running Fibonacci shift register used as the random source.
// Assumes TAPS selects a maximal-length polynomial and SEED is nonzero.
module prc_lfsr #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  SEED = '1,
    parameter logic [W-1:0]  TAPS = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    logic feedback;

    // Parity of tapped bits forms the incoming bit.
    always_comb feedback = ^(state & TAPS);

    // Advance once per cycle, reload the seed under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= {state[W-2:0], feedback};
    end
endmodule

// File: rtl/prc_hit_est.sv
// Exponentially smoothed hit-ratio estimate in unsigned fixed point.
// Assumes ALPHA + BLEND equals 2**W so a hit at full scale cannot overflow.
module prc_hit_est #(
    parameter int           W     = 16,
    parameter int           ALPHA = 58982,
    parameter int           BLEND = 6554,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic         hit,
    output logic [W-1:0] est
);
    localparam logic [W-1:0] ALPHA_V = W'(ALPHA);
    localparam logic [W-1:0] BLEND_V = W'(BLEND);

    logic [2*W-1:0] product;
    logic [W-1:0]   scaled;
    logic [W-1:0]   est_nxt;

    // Decay the old value and add the blend term on a hit.
    always_comb begin
        product = est * ALPHA_V;
        scaled  = product[2*W-1:W];
        est_nxt = hit ? scaled + BLEND_V : scaled;
    end

    // Update the estimate on each lookup.
    always_ff @(posedge clk) begin
        if (!rst_n)   est <= INIT;
        else if (upd) est <= est_nxt;
    end
endmodule

// File: rtl/prc_victim.sv
// Combinational replacement decision for one miss.
// Fills the lowest free way unconditionally; on a full set, grants with
// probability est / 2**W and picks the victim from the low random byte.
module prc_victim #(
    parameter int WAYS  = 4,
    parameter int W     = 16,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [W-1:0]     rnd,
    input  logic [W-1:0]     est,
    output logic             grant,
    output logic [WAY_W-1:0] way
);
    localparam int PICK_W = 8;

    logic             has_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] rnd_way;

    // Scan from the top so the lowest free way wins.
    always_comb begin
        has_free = 1'b0;
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                has_free = 1'b1;
                free_way = WAY_W'(i);
            end
        end
    end

    // Reduce the low random byte to a way index.
    always_comb rnd_way = WAY_W'(32'(rnd[PICK_W-1:0]) % WAYS);

    // Choose between filling a free way and the probability test.
    always_comb begin
        if (has_free) begin
            grant = 1'b1;
            way   = free_way;
        end else begin
            grant = (rnd < est);
            way   = grant ? rnd_way : '0;
        end
    end
endmodule

// File: rtl/prob_repl_ctrl.sv
// Top of the adaptive probabilistic replacement controller.
// Assumes at most one lookup per cycle; the grant and victim for a miss
// are registered and presented in the following cycle.
module prob_repl_ctrl #(
    parameter int WAYS  = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lookup_vld,
    input  logic                        lookup_hit,
    input  logic [WAYS-1:0]             set_valid,
    output logic                        repl_en,
    output logic [WAY_W-1:0]            repl_way,
    output logic [prc_pkg::EST_W-1:0]   hit_est
);
    import prc_pkg::*;

    logic [RND_W-1:0] rnd;
    logic             grant;
    logic [WAY_W-1:0] way;
    logic             miss;

    prc_lfsr #(.W(RND_W), .SEED(RND_SEED), .TAPS(RND_TAPS)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rnd)
    );

    prc_hit_est #(.W(EST_W), .ALPHA(ALPHA_Q), .BLEND(BLEND_Q), .INIT(EST_INIT)) u_est (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (lookup_vld),
        .hit   (lookup_hit),
        .est   (hit_est)
    );

    prc_victim #(.WAYS(WAYS), .W(EST_W), .WAY_W(WAY_W)) u_victim (
        .valid (set_valid),
        .rnd   (rnd),
        .est   (hit_est),
        .grant (grant),
        .way   (way)
    );

    // A miss is a presented lookup without a hit.
    always_comb miss = lookup_vld && !lookup_hit;

    // Register the decision so it appears one cycle after the miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            repl_en  <= 1'b0;
            repl_way <= '0;
        end else begin
            repl_en  <= miss && grant;
            repl_way <= (miss && grant) ? way : '0;
        end
    end
endmodule

// File: rtl/prob_repl_ctrl_chk.sv
// Port-level properties of the replacement controller, bound to the top.
module prob_repl_ctrl_chk #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lookup_vld,
    input logic             lookup_hit,
    input logic [WAYS-1:0]  set_valid,
    input logic             repl_en,
    input logic [WAY_W-1:0] repl_way,
    input logic [15:0]      hit_est
);
    logic past_ok;

    // Marks cycles whose predecessor was out of reset.
    always_ff @(posedge clk) past_ok <= rst_n;

    a_r8_no_grant_without_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !(lookup_vld && !lookup_hit) |=> !repl_en);

    a_r4_est_holds_idle: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !lookup_vld |=> $stable(hit_est));

    a_r3_miss_never_grows: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (lookup_vld && !lookup_hit) |=> hit_est <= $past(hit_est));

    a_r2_hit_never_shrinks: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (lookup_vld && lookup_hit) |=> hit_est >= $past(hit_est));

    a_r5_free_way_filled: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_vld && !lookup_hit && !(&set_valid)) |=> repl_en);

    a_r7_way_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        repl_en |-> 32'(repl_way) < WAYS);

    a_r7_way_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !repl_en |-> repl_way == '0);
endmodule

bind prob_repl_ctrl prob_repl_ctrl_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookup_vld (lookup_vld),
    .lookup_hit (lookup_hit),
    .set_valid  (set_valid),
    .repl_en    (repl_en),
    .repl_way   (repl_way),
    .hit_est    (hit_est)
);

// File: tb/test_prob_repl_ctrl.sv
module test_prob_repl_ctrl;
    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lookup_vld = 1'b0;
    logic             lookup_hit = 1'b0;
    logic [WAYS-1:0]  set_valid = '1;
    logic             repl_en;
    logic [WAY_W-1:0] repl_way;
    logic [15:0]      hit_est;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Expected state computed from the requirements
    logic [15:0] m_h;
    logic [15:0] m_rnd;
    logic        m_en;
    logic [1:0]  m_way;

    always #4 clk = ~clk;   // 125 MHz

    prob_repl_ctrl #(.WAYS(WAYS)) i_prob_repl_ctrl (
        .clk(clk), .rst_n(rst_n), .lookup_vld(lookup_vld), .lookup_hit(lookup_hit),
        .set_valid(set_valid), .repl_en(repl_en), .repl_way(repl_way), .hit_est(hit_est)
    );

    // Reference model, evaluated on the same edges as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_h = 16'h8000; m_rnd = 16'hACE1; m_en = 1'b0; m_way = 2'd0;
        end else begin
            m_en = 1'b0; m_way = 2'd0;
            if (lookup_vld && !lookup_hit) begin
                if (!(&set_valid)) begin
                    m_en = 1'b1;
                    for (int i = WAYS - 1; i >= 0; i--) if (!set_valid[i]) m_way = 2'(i);
                end else if (m_rnd < m_h) begin
                    m_en = 1'b1;
                    m_way = 2'(int'(m_rnd[7:0]) % WAYS);
                end
            end
            if (lookup_vld) begin
                m_h = 16'((32'(m_h) * 58982) >> 16);
                if (lookup_hit) m_h = m_h + 16'd6554;
            end
            m_rnd = {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "hit_est", int'(hit_est), int'(m_h));
        check(req, "repl_en", int'(repl_en), int'(m_en));
        check(req, "repl_way", int'(repl_way), int'(m_way));
    endtask

    // One cycle of stimulus; outputs checked at the following falling edge.
    task automatic step(input logic vld, input logic hit, input logic [WAYS-1:0] vmask);
        lookup_vld = vld; lookup_hit = hit; set_valid = vmask;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(1'b1, 1'b0, 4'b0000);
        check_all("R1");
        check("R1", "reset hit_est", int'(hit_est), 32768);
        check("R1", "reset repl_en", int'(repl_en), 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 4'b1111);
        check("R1", "post-reset hit_est", int'(hit_est), 32768);
        check("R4", "post-reset repl_en", int'(repl_en), 0);
    endtask

    task automatic t_hits;
        logic [15:0] prev;
        prev = hit_est;
        step(1'b1, 1'b1, 4'b1111);
        check("R2", "one hit", int'(hit_est), int'(((32'(prev) * 58982) >> 16) + 6554));
        check("R8", "no grant on hit", int'(repl_en), 0);
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b1, 4'b0101);
            check_all("R2");
        end
    endtask

    task automatic t_idle;
        logic [15:0] prev;
        prev = hit_est;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, 4'b0000);
            check("R4", "idle hold", int'(hit_est), int'(prev));
            check("R4", "idle repl_en", int'(repl_en), 0);
        end
    endtask

    task automatic t_fill;
        logic [15:0] prev;
        logic [3:0] masks [4] = '{4'b0000, 4'b0001, 4'b1011, 4'b0111};
        int exp_way [4] = '{0, 1, 2, 3};
        foreach (masks[k]) begin
            prev = hit_est;
            step(1'b1, 1'b0, masks[k]);
            check("R5", "fill grant", int'(repl_en), 1);
            check("R5", "fill way", int'(repl_way), exp_way[k]);
            check("R3", "miss decay", int'(hit_est), int'((32'(prev) * 58982) >> 16));
        end
        step(1'b0, 1'b0, 4'b0000);
        check("R8", "pulse ends", int'(repl_en), 0);
    endtask

    task automatic t_full(input int n_hits_between);
        int grants = 0;
        int refusals = 0;
        for (int i = 0; i < 60; i++) begin
            for (int j = 0; j < n_hits_between; j++) step(1'b1, 1'b1, 4'b1111);
            step(1'b1, 1'b0, 4'b1111);
            check_all("R6");
            if (repl_en) begin
                grants++;
                check_all("R7");
            end else begin
                refusals++;
                check("R7", "idle way", int'(repl_way), 0);
            end
            step(1'b0, 1'b0, 4'b1111);
            check("R8", "single cycle", int'(repl_en), 0);
        end
        check("R6", "grants seen", int'(grants > 0), 1);
        check("R6", "refusals seen", int'(refusals > 0), 1);
    endtask

    task automatic t_extremes;
        for (int i = 0; i < 150; i++) step(1'b1, 1'b1, 4'b1111);
        check("R9", "hits high", int'(hit_est >= 16'd65000), 1);
        check_all("R9");
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 4'b1111);
        check("R9", "misses to zero", int'(hit_est), 0);
        step(1'b1, 1'b0, 4'b1111);
        check("R6", "zero estimate refuses", int'(repl_en), 0);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_hits();
        t_idle();
        t_fill();
        t_full(3);
        t_full(0);
        t_extremes();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule